// File: doc/BRIEF.md
# GPIO Bank with Edge Detection

This block controls one bank of 32 general-purpose pins through a small synchronous register bus. Software chooses each pin's direction. It raises output levels through a write-ones-to-set register and lowers them through a write-ones-to-clear register, so no read-modify-write cycle is needed to change one pin. It can also read the synchronized level of every pin, whatever its direction. Each pin also carries a 2-bit alternate-function code, which the block presents on a flat output vector for muxes that sit outside this block.

Every pin input passes through a two-flop synchronizer. A transition is found by comparing the synchronized level with its value one cycle earlier. Per-pin rising and falling enables decide which transitions latch a bit in a sticky status register. Software clears a status bit by writing a 1 to it. A single active-high level interrupt is raised while any status bit is set.

The bus is a single-cycle access. A write commits at the clock edge on which `bus_valid` and `bus_write` are both high. The read data is combinational from `bus_addr`. Word offsets are decoded from `bus_addr[5:2]`. An address with upper bits set, or with an index above 8, reads 0 and ignores writes.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every register reads 0, `pin_oe`, `pin_out` and `pin_func` are all 0, and `irq` is low.
- R2: A write to the set register (offset 0x08) makes `pin_out[n]` 1 for every bit n that is 1 in the write data, and leaves the other bits unchanged. A read of 0x08 returns 0.
- R3: A write to the clear register (offset 0x0C) makes `pin_out[n]` 0 for every bit n that is 1 in the write data, and leaves the other bits unchanged. A read of 0x0C returns 0.
- R4: The direction register (offset 0x04) reads back what was written and drives `pin_oe`, where 1 means output. It changes only when it is written.
- R5: The level register (offset 0x00) returns the pin inputs as they were two clocks earlier, for input pins and output pins alike.
- R6: When bit n of the rising enable (offset 0x10) is 1, a 0-to-1 change on `pin_in[n]` sets bit n of the edge status register (offset 0x18) on the third rising clock edge after the change.
- R7: When bit n of the falling enable (offset 0x14) is 1, a 1-to-0 change sets status bit n. A pin with both enables set catches both directions.
- R8: A transition whose direction is not enabled for that pin leaves its status bit unchanged.
- R9: Status bits are sticky. Writing 1 to a bit at 0x18 clears it, and writing 0 leaves it unchanged.
- R10: If an enabled edge is detected on the same clock edge on which software writes 1 to clear that bit, the bit stays set.
- R11: The function registers at 0x1C (pins 0 to 15) and 0x20 (pins 16 to 31) read back what was written. The code of pin n sits at bits [2*(n mod 16)+1 : 2*(n mod 16)] of its word and appears on `pin_func[2n+1:2n]`.
- R12: `irq` is high exactly while at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Output levels |
| pin_oe | output | 32 | Output enables (1 = drive) |
| pin_func | output | 64 | Alternate-function codes, 2 bits per pin |
| irq | output | 1 | OR of all edge status bits |

## Verification
The bench builds the block with its default parameters: 32 pins, 2-bit function codes and an 8-bit byte address. With these values the whole map is exercised, including the split of the function codes into two words. A table walks writes to every writable register and checks read-back together with the output vector. Directed sequences then time edges through the synchronizer, mix enabled and disabled directions on neighbouring pins, and place a clear write on exactly the cycle in which an edge lands.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    typedef enum logic [3:0] {
        REG_LEVEL   = 4'd0,
        REG_DIR     = 4'd1,
        REG_SET     = 4'd2,
        REG_CLR     = 4'd3,
        REG_RISE    = 4'd4,
        REG_FALL    = 4'd5,
        REG_STAT    = 4'd6,
        REG_FUNC_LO = 4'd7,
        REG_FUNC_HI = 4'd8,
        REG_NONE    = 4'd15
    } reg_sel_e;

    localparam int unsigned LAST_INDEX = 8;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] level,
    output logic [PINS-1:0] level_q
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic meta;
        logic stable;
        logic last;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta   <= 1'b0;
                stable <= 1'b0;
                last   <= 1'b0;
            end else begin
                meta   <= pin_in[i];
                stable <= meta;
                last   <= stable;
            end
        end
        assign level[i]   = stable;
        assign level_q[i] = last;
    end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] level,
    input  logic [PINS-1:0] level_q,
    input  logic [PINS-1:0] rise_en,
    input  logic [PINS-1:0] fall_en,
    input  logic            clr_we,
    input  logic [PINS-1:0] clr_mask,
    output logic [PINS-1:0] status
);
    logic [PINS-1:0] hit;
    logic [PINS-1:0] wipe;

    always_comb begin
        hit  = (level & ~level_q & rise_en) | (~level & level_q & fall_en);
        wipe = clr_we ? clr_mask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~wipe) | hit;
    end

    // R10: a detected edge always leaves its bit set
    a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((status & $past(hit)) == $past(hit)));

    // R9: without a clear write no bit falls
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we) |=> ((status & $past(status)) == $past(status)));

    // R9: cleared bits without a concurrent edge drop
    a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status & $past(clr_mask & ~hit)) == '0));
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_edge_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  reg_sel_e        sel,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] dir,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] rise_en,
    output logic [PINS-1:0] fall_en,
    output logic [PINS-1:0] func_lo,
    output logic [PINS-1:0] func_hi
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir     <= '0;
            pin_out <= '0;
            rise_en <= '0;
            fall_en <= '0;
            func_lo <= '0;
            func_hi <= '0;
        end else if (we) begin
            unique case (sel)
                REG_DIR:     dir     <= wdata;
                REG_SET:     pin_out <= pin_out | wdata;
                REG_CLR:     pin_out <= pin_out & ~wdata;
                REG_RISE:    rise_en <= wdata;
                REG_FALL:    fall_en <= wdata;
                REG_FUNC_LO: func_lo <= wdata;
                REG_FUNC_HI: func_hi <= wdata;
                default:     ;
            endcase
        end
    end

    a_r2_set_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == REG_SET) |=> ((pin_out & $past(wdata)) == $past(wdata)));

    a_r3_clear_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == REG_CLR) |=> ((pin_out & $past(wdata)) == '0));

    a_r4_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == REG_DIR) |=> $stable(dir));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int unsigned PINS   = 32,
    parameter int unsigned FUNC_W = 2,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [PINS-1:0]        bus_wdata,
    output logic [PINS-1:0]        bus_rdata,
    input  logic [PINS-1:0]        pin_in,
    output logic [PINS-1:0]        pin_out,
    output logic [PINS-1:0]        pin_oe,
    output logic [FUNC_W*PINS-1:0] pin_func,
    output logic                   irq
);
    localparam int unsigned IDX_W = 4;
    localparam int unsigned IDX_HI = IDX_W + 1;

    reg_sel_e        sel;
    logic [IDX_W-1:0] idx;
    logic            we;
    logic [PINS-1:0] level, level_q, status;
    logic [PINS-1:0] dir, rise_en, fall_en, func_lo, func_hi;

    always_comb begin
        idx = bus_addr[IDX_HI:2];
        if (bus_addr[ADDR_W-1:IDX_HI+1] == '0 && idx <= IDX_W'(LAST_INDEX))
            sel = reg_sel_e'(idx);
        else
            sel = REG_NONE;
        we = bus_valid && bus_write;
    end

    gpio_in_sync #(.PINS(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .level   (level),
        .level_q (level_q)
    );

    gpio_ctrl_regs #(.PINS(PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .sel     (sel),
        .wdata   (bus_wdata),
        .dir     (dir),
        .pin_out (pin_out),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .func_lo (func_lo),
        .func_hi (func_hi)
    );

    gpio_edge_status #(.PINS(PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .level_q  (level_q),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .clr_we   (we && sel == REG_STAT),
        .clr_mask (bus_wdata),
        .status   (status)
    );

    always_comb begin
        unique case (sel)
            REG_LEVEL:   bus_rdata = level;
            REG_DIR:     bus_rdata = dir;
            REG_RISE:    bus_rdata = rise_en;
            REG_FALL:    bus_rdata = fall_en;
            REG_STAT:    bus_rdata = status;
            REG_FUNC_LO: bus_rdata = func_lo;
            REG_FUNC_HI: bus_rdata = func_hi;
            default:     bus_rdata = '0;
        endcase
    end

    assign pin_oe   = dir;
    assign pin_func = {func_hi, func_lo};
    assign irq      = |status;

    // R12: the interrupt falls only through a status-clear write
    a_r12_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(we && sel == REG_STAT)) |=> irq);
endmodule

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;
    localparam int PERIOD = 10;
    localparam int NVEC = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic [63:0] pin_func;
    logic        irq;
    int          n_run = 0;
    int          n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    gpio_edge_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_func(pin_func), .irq(irq)
    );

    // {write addr, write data, read addr, expected read, expected pin_out}
    localparam logic [111:0] VEC [NVEC] = '{
        {8'h04, 32'h0000FFFF, 8'h04, 32'h0000FFFF, 32'h00000000}, // R4
        {8'h08, 32'h000000F0, 8'h08, 32'h00000000, 32'h000000F0}, // R2
        {8'h0C, 32'h00000030, 8'h0C, 32'h00000000, 32'h000000C0}, // R3
        {8'h08, 32'h0000000F, 8'h04, 32'h0000FFFF, 32'h000000CF}, // R2
        {8'h10, 32'hAAAA5555, 8'h10, 32'hAAAA5555, 32'h000000CF}, // R6
        {8'h14, 32'h0F0F0F0F, 8'h14, 32'h0F0F0F0F, 32'h000000CF}, // R7
        {8'h1C, 32'h12345678, 8'h1C, 32'h12345678, 32'h000000CF}, // R11
        {8'h20, 32'h9ABCDEF0, 8'h20, 32'h9ABCDEF0, 32'h000000CF}, // R11
        {8'h0C, 32'h0000000C, 8'h08, 32'h00000000, 32'h000000C3}  // R3
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_out", {32'h0, pin_out}, 64'h0);
        check("R1 pin_oe", {32'h0, pin_oe}, 64'h0);
        check("R1 pin_func", pin_func, 64'h0);
        check("R1 irq", {63'h0, irq}, 64'h0);
        for (int a = 4; a <= 32; a += 4) begin
            rd(8'(a), r);
            check("R1 reg", {32'h0, r}, 64'h0);
        end

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][111:104], VEC[i][103:72]);
            rd(VEC[i][71:64], r);
            check("table read", {32'h0, r}, {32'h0, VEC[i][63:32]});
            check("table pin_out", {32'h0, pin_out}, {32'h0, VEC[i][31:0]});
        end
        check("R4 pin_oe", {32'h0, pin_oe}, 64'h0000FFFF);
        // R11: pin1 = 2, pin18 = 3, pin31 = 2
        check("R11 pin1", {62'h0, pin_func[3:2]}, 64'd2);
        check("R11 pin18", {62'h0, pin_func[37:36]}, 64'd3);
        check("R11 pin31", {62'h0, pin_func[63:62]}, 64'd2);

        // R5: level seen for output and input pins alike
        pin_in = 32'hDEADBEEF;
        @(negedge clk); @(negedge clk);
        rd(8'h00, r);
        check("R5 level", {32'h0, r}, 64'hDEADBEEF);

        // R8: these edges hit pins whose direction is disabled or were pre-enable
        pin_in = 32'h0;
        settle();
        wr(8'h10, 32'h0);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'hFFFFFFFF);
        rd(8'h18, r);
        check("R9 clear all", {32'h0, r}, 64'h0);
        pin_in = 32'hFFFF0000;
        settle();
        rd(8'h18, r);
        check("R8 disabled edges", {32'h0, r}, 64'h0);
        pin_in = 32'h0;
        settle();

        // rise: pins 0 and 2; fall: pins 1 and 2
        wr(8'h10, 32'h5);
        wr(8'h14, 32'h6);
        pin_in = 32'h7;
        @(negedge clk); @(negedge clk);
        rd(8'h18, r);
        check("R6 not before third edge", {32'h0, r}, 64'h0);
        @(negedge clk);
        rd(8'h18, r);
        check("R6 R8 rising", {32'h0, r}, 64'h5);
        check("R12 irq high", {63'h0, irq}, 64'h1);
        pin_in = 32'h0;
        settle();
        rd(8'h18, r);
        check("R7 falling and both", {32'h0, r}, 64'h7);
        wr(8'h18, 32'h1);
        rd(8'h18, r);
        check("R9 zeros keep", {32'h0, r}, 64'h6);
        check("R12 irq still", {63'h0, irq}, 64'h1);
        wr(8'h18, 32'h6);
        rd(8'h18, r);
        check("R9 cleared", {32'h0, r}, 64'h0);
        check("R12 irq low", {63'h0, irq}, 64'h0);

        // R10: edge lands on the same clock as a clear of that bit
        pin_in = 32'h4;
        settle();
        rd(8'h18, r);
        check("R10 setup", {32'h0, r}, 64'h4);
        pin_in = 32'h0;
        @(negedge clk);
        wr(8'h18, 32'h4);
        rd(8'h18, r);
        check("R10 edge wins", {32'h0, r}, 64'h4);
        wr(8'h18, 32'h4);
        rd(8'h18, r);
        check("R10 later clear", {32'h0, r}, 64'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 50000);
        n_run++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule